// File: doc/BRIEF.md
# Rotating Load Aligner

This block sits between a 32-bit core's load unit and a memory that answers only aligned word reads. The core hands it a byte address, an access size, a sign-extension flag and the current endianness. The block issues one read of the aligned word that encloses the address. When the read data comes back, it turns that word into the register value, one cycle later.

Misalignment is never an error and never costs a second access. A word load at a misaligned address returns the enclosing aligned word, rotated by the byte offset. Byte loads pick one byte lane. Halfword loads take one word access: the word is rotated so that the wanted halfword sits in the upper half of the register, and is then shifted down into bits 15:0. In both byte orders the result follows from the low two address bits and the endianness setting, so legacy code that relies on rotate-on-misalignment keeps working.

Only one load is outstanding at a time. A completing load and a newly accepted request may share a cycle, so back-to-back loads run without a bubble.

Top module: `rot_load_unit`

## Requirements
- R1: A request is accepted at a clock edge where `req_valid` is high and either no load is outstanding or `mem_rvalid` is high. Each accepted request raises `mem_rd` for exactly the following cycle. A request made while a load is outstanding and `mem_rvalid` is low is ignored: `mem_rd` stays low.
- R2: `mem_addr` carries the accepted `req_addr` with bits 1:0 cleared. It holds that value until the next accepted request.
- R3: Word load, little-endian (`big_endian`=0): with offset k = addr[1:0], the result is the fetched word rotated right by 8·k bits. An aligned word is returned unchanged.
- R4: Word load, big-endian: the result is the fetched word rotated left by 8·k bits. In this order, the byte at the lowest address of the word occupies bits 31:24 of the fetched word.
- R5: `res_valid` is a one-cycle pulse in the cycle after `mem_rvalid` is high while a load is outstanding. `res_data` is valid in that cycle. A `mem_rvalid` with no load outstanding is ignored.
- R6: Byte load: byte i of the fetched word is bits 8i+7:8i in little-endian and bits 31-8i:24-8i in big-endian. The result is byte k, zero-extended, or sign-extended from bit 7 when `req_signed` is 1.
- R7: Halfword load: the result is {byte (k+1) mod 4, byte k} in little-endian and {byte k, byte (k+1) mod 4} in big-endian, using byte i as defined in R6. It is zero-extended, or sign-extended from bit 15 when `req_signed` is 1.
- R8: `req_size` encoding: 00 byte, 01 halfword, 10 word; 11 behaves as word.
- R9: Size, offset, sign flag and endianness are captured when a request is accepted. Changing those inputs while the load is outstanding has no effect on its result.
- R10: When completion (`mem_rvalid`) and a new request fall in the same cycle, the old load's result uses the old attributes. The new request is accepted and issued in the next cycle.
- R11: During and right after reset, `mem_rd` and `res_valid` are low, and `mem_addr` and `res_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend byte and halfword results |
| big_endian | input | 1 | Byte order for this request |
| mem_rd | output | 1 | One-cycle read strobe |
| mem_addr | output | AW | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| res_valid | output | 1 | Result valid pulse |
| res_data | output | 32 | Register value after rotation and extension |

## Verification
The two functions that can share a cycle are completion of the outstanding load and acceptance of the next request. The bench provokes this by driving `mem_rvalid` and `req_valid` together, with the two requests using different sizes, offsets and byte orders. The bench's cycle model then checks that `res_data` follows the old load's captured attributes, and that `mem_rd` and `mem_addr` reflect the new request one cycle later. The same model also checks the cases where the new request is dropped: a request with a load outstanding and no read data, and a stray `mem_rvalid` with nothing outstanding.

// File: rtl/rot_load_unit.sv
module rot_load_unit #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic          big_endian,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  output logic [DW-1:0] res_data
);
  localparam int LANES = DW / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int HALFL = LANES - 2;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic            pend;
  logic [OFFW-1:0] q_off;
  logic [1:0]      q_size;
  logic            q_sgn;
  logic            q_be;
  wire             accept = req_valid && (!pend || mem_rvalid);
  wire             done   = mem_rvalid && pend;

  logic [DW-1:0] swapped;
  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_swap
      assign swapped[8*gi +: 8] = mem_rdata[DW-1-8*gi -: 8];
    end
  endgenerate

  wire [DW-1:0]   lanes   = q_be ? swapped : mem_rdata;
  wire [2*DW-1:0] dbl     = {lanes, lanes};
  wire [OFFW-1:0] off_hi  = q_off + OFFW'(HALFL);
  wire [DW-1:0]   rot     = DW'(dbl >> {q_off, 3'b000});
  wire [DW-1:0]   rot_top = DW'(dbl >> {off_hi, 3'b000});

  logic [DW-1:0] rot_out;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_back
      assign rot_out[8*gi +: 8] = q_be ? rot[DW-1-8*gi -: 8] : rot[8*gi +: 8];
    end
  endgenerate

  wire [15:0] half_le = rot_top[DW-1 -: 16];
  wire [15:0] half_be = {rot_top[DW-9 -: 8], rot_top[DW-1 -: 8]};
  wire [15:0] half_v  = q_be ? half_be : half_le;
  wire [7:0]  byte_v  = rot[7:0];

  logic [DW-1:0] shaped;
  always_comb begin
    case (q_size)
      SZ_BYTE: shaped = {{(DW-8){q_sgn & byte_v[7]}}, byte_v};
      SZ_HALF: shaped = {{(DW-16){q_sgn & half_v[15]}}, half_v};
      default: shaped = rot_out;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      mem_rd    <= 1'b0;
      mem_addr  <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      q_off     <= '0;
      q_size    <= '0;
      q_sgn     <= 1'b0;
      q_be      <= 1'b0;
    end else begin
      mem_rd    <= accept;
      res_valid <= done;
      if (done) res_data <= shaped;
      if (accept) begin
        pend     <= 1'b1;
        mem_addr <= {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
        q_off    <= req_addr[OFFW-1:0];
        q_size   <= req_size;
        q_sgn    <= req_signed;
        q_be     <= big_endian;
      end else if (done) begin
        pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rot_load_unit_chk.sv
module rot_load_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          mem_rd,
  input logic [1:0]    mem_lo,
  input logic          mem_rvalid,
  input logic [DW-1:0] mem_rdata,
  input logic          res_valid,
  input logic [DW-1:0] res_data,
  input logic [1:0]    q_size,
  input logic [1:0]    q_off,
  input logic          q_sgn,
  input logic          q_be
);
  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(req_valid)); // R1

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_lo == 2'b00)); // R2

  AST_RES_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(mem_rvalid)); // R5

  AST_ALIGNED_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(q_size[1] && q_off == 2'b00 && !q_be)) |-> (res_data == $past(mem_rdata))); // R3

  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(q_size == 2'b00 && !q_sgn)) |-> (res_data[DW-1:8] == '0)); // R6
endmodule

bind rot_load_unit rot_load_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_rd(mem_rd),
  .mem_lo(mem_addr[1:0]), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
  .res_valid(res_valid), .res_data(res_data), .q_size(q_size),
  .q_off(q_off), .q_sgn(q_sgn), .q_be(q_be)
);

// File: tb/rot_load_unit_tb.sv
module rot_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        big_endian = 1'b0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rot_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [31:0] model(input logic [31:0] w, input int off,
                                        input logic [1:0] sz, input bit sgn, input bit be);
    logic [7:0]  b [4];
    logic [31:0] v;
    logic [15:0] h;
    for (int i = 0; i < 4; i++) b[i] = be ? w[31-8*i -: 8] : w[8*i +: 8];
    v = '0;
    if (sz == 2'b00) begin
      v = sgn ? {{24{b[off][7]}}, b[off]} : {24'h0, b[off]};
    end else if (sz == 2'b01) begin
      h = be ? {b[off], b[(off+1)%4]} : {b[(off+1)%4], b[off]};
      v = sgn ? {{16{h[15]}}, h} : {16'h0, h};
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (be) v[31-8*k -: 8] = b[(off+k)%4];
        else    v[8*k +: 8]    = b[(off+k)%4];
      end
    end
    return v;
  endfunction

  bit          m_pend = 0;
  bit          e_rd = 0;
  bit          e_rv = 0;
  logic [31:0] e_addr = '0;
  logic [31:0] e_data = '0;
  int          s_off = 0;
  logic [1:0]  s_size = '0;
  bit          s_sgn = 0;
  bit          s_be = 0;
  string       e_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; e_rd = 0; e_rv = 0; e_addr = '0; e_data = '0;
    end else begin
      bit acc;
      acc  = req_valid && (!m_pend || mem_rvalid);
      e_rv = mem_rvalid && m_pend;
      if (e_rv) begin
        e_data = model(mem_rdata, s_off, s_size, s_sgn, s_be);
        e_tag  = (s_size == 2'b00) ? "R6" : (s_size == 2'b01) ? "R7" :
                 (s_size == 2'b11) ? (s_be ? "R8/R4" : "R8/R3") : (s_be ? "R4" : "R3");
      end
      e_rd = acc;
      if (acc) begin
        e_addr = {req_addr[31:2], 2'b00};
        s_off = int'(req_addr[1:0]); s_size = req_size; s_sgn = req_signed; s_be = big_endian;
        m_pend = 1;
      end else if (e_rv) begin
        m_pend = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      chk("R1 mem_rd", {31'h0, mem_rd}, {31'h0, e_rd});
      chk("R2 mem_addr", mem_addr, e_addr);
      chk("R5 res_valid", {31'h0, res_valid}, {31'h0, e_rv});
      if (e_rv && res_valid) chk(e_tag, res_data, e_data);
    end
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic issue(input logic [31:0] a, input logic [1:0] sz, input bit sg, input bit be);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_signed = sg; big_endian = be;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic respond(input logic [31:0] d, input int gap);
    repeat (gap) @(negedge clk);
    mem_rvalid = 1; mem_rdata = d;
    @(negedge clk);
    mem_rvalid = 0;
  endtask

  initial begin
    logic [31:0] pats [3];
    pats[0] = 32'h8A3C_F157;
    pats[1] = 32'h17E2_64B9;
    pats[2] = 32'hC0FF_EE11;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 mem_rd", {31'h0, mem_rd}, 32'h0);
    chk("R11 res_valid", {31'h0, res_valid}, 32'h0);
    chk("R11 mem_addr", mem_addr, 32'h0);
    chk("R11 res_data", res_data, 32'h0);
    rst_n = 1;

    // R3 R4 R6 R7 R8: every offset, size code, sign flag and byte order
    for (int p = 0; p < 3; p++)
      for (int be = 0; be < 2; be++)
        for (int sz = 0; sz < 4; sz++)
          for (int sg = 0; sg < 2; sg++)
            for (int off = 0; off < 4; off++) begin
              issue(32'h0000_8004 + 32'(off) + 32'(p*16), 2'(sz), bit'(sg), bit'(be));
              respond(pats[p], p);
            end

    // R9: inputs change while outstanding
    issue(32'h0000_8006, 2'b10, 0, 0);
    @(negedge clk);
    req_size = 2'b00; big_endian = 1; req_signed = 1; req_addr = 32'h0000_9003;
    respond(32'h1122_3344, 1);

    // R1: request while outstanding is ignored
    issue(32'h0000_A001, 2'b01, 1, 1);
    issue(32'h0000_B002, 2'b00, 0, 0);
    respond(32'h9F80_7E01, 1);

    // R5: stray read data is ignored
    respond(32'hDEAD_BEEF, 2);
    repeat (2) @(negedge clk);

    // R10: completion and new request in the same cycle
    issue(32'h0000_C003, 2'b10, 0, 1);
    @(negedge clk);
    mem_rvalid = 1; mem_rdata = 32'hA1B2_C3D4;
    req_valid = 1; req_addr = 32'h0000_D002; req_size = 2'b01; req_signed = 1; big_endian = 0;
    @(negedge clk);
    mem_rvalid = 0; req_valid = 0;
    respond(32'h80F0_0F08, 1);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule